// File: doc/BRIEF.md
# Signed Integer Format Converter

This block re-encodes a W-bit signed integer (W defaults to 8) from one of four signed encodings into another: sign-magnitude, one's complement, two's complement and excess-bias, where the bias is 2^(W-1). Each input word is first turned into a two's-complement value. That value is then encoded in the requested destination format. This keeps the number of conversion paths at four decoders and four encoders rather than sixteen direct translations.

A caller presents a data word together with a source-format code and a destination-format code, and raises the valid strobe. One clock later the converted word appears on the registered output, with a matching valid flag. Two further flags come with the result. The first reports that the value does not fit the destination format. This happens only for the most negative two's-complement value, which cannot be expressed in sign-magnitude or one's complement. The second reports that the input was a negative-zero pattern.

Top module: `intcode_conv`

## Requirements
- R1: Format codes are 2'b00 sign-magnitude, 2'b01 one's complement, 2'b10 two's complement and 2'b11 excess-bias. A conversion into two's complement yields the true value of the input as a W-bit two's-complement pattern.
- R2: Sign-magnitude uses the top bit as the sign (1 is negative) and the lower W-1 bits as the magnitude. Conversions into and out of this format preserve the value over -(2^(W-1)-1) to +(2^(W-1)-1).
- R3: One's complement negates a value by inverting every bit. Conversions into and out of this format preserve the value over -(2^(W-1)-1) to +(2^(W-1)-1).
- R4: Excess-bias equals the two's-complement pattern with its top bit inverted, so zero is 1 followed by zeros. Conversions into and out of this format preserve the value over the full two's-complement range.
- R5: For W=8, the value -123 is 8'hFB in sign-magnitude, 8'h84 in one's complement, 8'h85 in two's complement and 8'h05 in excess-bias.
- R6: When the value is -2^(W-1) and the destination is sign-magnitude or one's complement, out_unrep is 1 and the output is saturated to -(2^(W-1)-1). For W=8 that output is 8'hFF in sign-magnitude and 8'h80 in one's complement.
- R7: When the value is -2^(W-1) and the destination is two's complement or excess-bias, the value converts exactly and out_unrep stays 0.
- R8: A negative-zero input converts to the destination's single zero pattern and raises out_negzero. The negative-zero inputs are the sign-magnitude pattern 1 followed by zeros, and the all-ones one's-complement pattern.
- R9: out_valid equals in_valid delayed by one clock. A result and its flags appear one clock after the inputs are sampled.
- R10: While rst_n is low at a clock edge, out_valid, out_data, out_unrep and out_negzero are cleared to 0.
- R11: In a cycle where in_valid is low, out_data keeps its previous value, and out_unrep and out_negzero are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word and format codes are valid |
| in_data | input | W | Input word in the source format |
| src_fmt | input | 2 | Source format code |
| dst_fmt | input | 2 | Destination format code |
| out_valid | output | 1 | Result valid, in_valid delayed by one clock |
| out_data | output | W | Converted word in the destination format |
| out_unrep | output | 1 | Value does not fit the destination, output saturated |
| out_negzero | output | 1 | Input was a negative-zero pattern |

## Verification
Every result is due exactly one rising edge after its inputs are sampled: the converted word, the unrepresentable flag, the negative-zero flag and the output valid all come from a single register stage. The bench changes its inputs on a falling edge and reads the outputs on the next falling edge. Each sample therefore sits half a period after the edge that loaded the register. An exhaustive sweep over all format pairs and all input patterns is checked against integer arithmetic. Directed tasks cover the worked value, the most negative value, the negative zeros, the hold behaviour and reset.

// File: rtl/intcode_pkg.sv
// Package intcode_pkg
// Shared encoding type for the signed-integer format converter.
// Assumes the format code is two bits wide and that its encoding is fixed.
package intcode_pkg;
    typedef enum logic [1:0] {
        FMT_SIGNMAG = 2'b00,
        FMT_ONESC   = 2'b01,
        FMT_TWOSC   = 2'b10,
        FMT_EXCESS  = 2'b11
    } num_fmt_t;
endpackage

// File: rtl/intcode_decode.sv
// Module intcode_decode
// Turns a word in any of the four signed encodings into its two's-complement value.
// It also flags the negative-zero patterns of sign-magnitude and one's complement.
// Assumes W >= 2. Purely combinational.
module intcode_decode
    import intcode_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] enc_in,
    input  num_fmt_t     fmt,
    output logic [W-1:0] tc_val,
    output logic         neg_zero
);
    localparam int          MAG_W = W - 1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] mag_ext;

    // Widen the sign-magnitude magnitude field to a full word.
    assign mag_ext = {1'b0, enc_in[MAG_W-1:0]};

    // Pick the decoding rule for the source format.
    always_comb begin
        tc_val   = enc_in;
        neg_zero = 1'b0;
        unique case (fmt)
            FMT_SIGNMAG: begin
                tc_val   = enc_in[W-1] ? (~mag_ext + ONE) : mag_ext;
                neg_zero = enc_in[W-1] && (enc_in[MAG_W-1:0] == '0);
            end
            FMT_ONESC: begin
                tc_val   = enc_in[W-1] ? (enc_in + ONE) : enc_in;
                neg_zero = &enc_in;
            end
            FMT_TWOSC: begin
                tc_val = enc_in;
            end
            FMT_EXCESS: begin
                tc_val = {~enc_in[W-1], enc_in[W-2:0]};
            end
            default: tc_val = enc_in;
        endcase
    end

    // R8: a negative zero must decode to the value zero.
    always_comb begin
        if (neg_zero) begin
            assert_negzero_value_R8: assert (tc_val == '0);
        end
    end
endmodule

// File: rtl/intcode_encode.sv
// Module intcode_encode
// Encodes a two's-complement value into the selected destination format.
// The most negative value cannot be written in sign-magnitude or one's complement.
// In those formats it is saturated to the largest negative magnitude and flagged.
// Assumes W >= 2. Purely combinational.
module intcode_encode
    import intcode_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] tc_val,
    input  num_fmt_t     fmt,
    output logic [W-1:0] enc_out,
    output logic         unrep
);
    localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE     = W'(1);

    logic         is_min;
    logic         is_neg;
    logic [W-1:0] abs_val;

    // Classify the value and form its magnitude.
    always_comb begin
        is_min  = (tc_val == MIN_VAL);
        is_neg  = tc_val[W-1];
        abs_val = ~tc_val + ONE;
    end

    // Apply the encoding rule of the destination format.
    always_comb begin
        enc_out = tc_val;
        unrep   = 1'b0;
        unique case (fmt)
            FMT_SIGNMAG: begin
                if (is_min) begin
                    enc_out = '1;
                    unrep   = 1'b1;
                end else if (is_neg) begin
                    enc_out = {1'b1, abs_val[W-2:0]};
                end
            end
            FMT_ONESC: begin
                if (is_min) begin
                    enc_out = MIN_VAL;
                    unrep   = 1'b1;
                end else if (is_neg) begin
                    enc_out = tc_val - ONE;
                end
            end
            FMT_TWOSC:  enc_out = tc_val;
            FMT_EXCESS: enc_out = {~tc_val[W-1], tc_val[W-2:0]};
            default:    enc_out = tc_val;
        endcase
    end
endmodule

// File: rtl/intcode_conv.sv
// Module intcode_conv (top)
// Registered signed-integer format converter: decode to two's complement, then encode.
// Result, flags and valid are due one clock after the inputs are sampled.
// Assumes a synchronous active-low reset and 2 <= W <= 32.
module intcode_conv
    import intcode_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic [1:0]   src_fmt,
    input  logic [1:0]   dst_fmt,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         out_unrep,
    output logic         out_negzero
);
    localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};

    num_fmt_t     src_e;
    num_fmt_t     dst_e;
    logic [W-1:0] mid_val;
    logic         mid_nz;
    logic [W-1:0] enc_word;
    logic         enc_unrep;

    // Map the raw format codes onto the shared type.
    assign src_e = num_fmt_t'(src_fmt);
    assign dst_e = num_fmt_t'(dst_fmt);

    intcode_decode #(.W(W)) u_dec (
        .enc_in   (in_data),
        .fmt      (src_e),
        .tc_val   (mid_val),
        .neg_zero (mid_nz)
    );

    intcode_encode #(.W(W)) u_enc (
        .tc_val  (mid_val),
        .fmt     (dst_e),
        .enc_out (enc_word),
        .unrep   (enc_unrep)
    );

    // Output stage: clear on reset, load data on valid, qualify flags with valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_unrep   <= 1'b0;
            out_negzero <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_unrep   <= in_valid & enc_unrep;
            out_negzero <= in_valid & mid_nz;
            if (in_valid) begin
                out_data <= enc_word;
            end
        end
    end

    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    assert_flags_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_unrep || out_negzero) |-> out_valid);

    assert_saturate_sm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_fmt == 2'b10 && in_data == MIN_VAL && dst_fmt == 2'b00)
        |=> (out_unrep && out_data == '1));

    assert_exact_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_fmt[1]) |=> !out_unrep);

    assert_negzero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_fmt == 2'b01 && in_data == '1) |=> out_negzero);
endmodule

// File: tb/intcode_conv_test.sv
module intcode_conv_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic [1:0]   src_fmt = 2'b00;
    logic [1:0]   dst_fmt = 2'b00;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic         out_unrep;
    logic         out_negzero;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    intcode_conv #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .src_fmt(src_fmt), .dst_fmt(dst_fmt), .out_valid(out_valid),
        .out_data(out_data), .out_unrep(out_unrep), .out_negzero(out_negzero)
    );

    function automatic int ref_value(input int fmt, input int pat);
        case (fmt)
            0: return (pat >= 128) ? -(pat - 128) : pat;
            1: return (pat >= 128) ? -(255 - pat) : pat;
            2: return (pat >= 128) ? pat - 256 : pat;
            default: return pat - 128;
        endcase
    endfunction

    function automatic int ref_pattern(input int fmt, input int v);
        case (fmt)
            0: return (v == -128) ? 255 : ((v < 0) ? 128 + (-v) : v);
            1: return (v == -128) ? 128 : ((v < 0) ? 255 - (-v) : v);
            2: return (v < 0) ? v + 256 : v;
            default: return v + 128;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input int s, input int d, input int pat);
        @(negedge clk);
        in_valid = 1'b1;
        src_fmt  = 2'(s);
        dst_fmt  = 2'(d);
        in_data  = W'(pat);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic conv_check(input string req, input int s, input int d, input int pat,
                              input int exp_data, input int exp_unrep, input int exp_nz);
        drive(s, d, pat);
        check(req, "data", int'(out_data), exp_data);
        check(req, "unrep", int'(out_unrep), exp_unrep);
        check(req, "negzero", int'(out_negzero), exp_nz);
    endtask

    // R10: reset clears every output
    task automatic test_reset();
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_data = 8'h80;
        src_fmt = 2'b10;
        dst_fmt = 2'b00;
        repeat (3) @(negedge clk);
        check("R10", "valid", int'(out_valid), 0);
        check("R10", "data", int'(out_data), 0);
        check("R10", "unrep", int'(out_unrep), 0);
        check("R10", "negzero", int'(out_negzero), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    // R1 R2 R3 R4: every format pair over every input pattern
    task automatic test_sweep();
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 4; d++) begin
                for (int p = 0; p < 256; p++) begin
                    int v = ref_value(s, p);
                    string tag;
                    case (d)
                        0: tag = "R2";
                        1: tag = "R3";
                        2: tag = "R1";
                        default: tag = "R4";
                    endcase
                    drive(s, d, p);
                    check(tag, "sweep data", int'(out_data), ref_pattern(d, v));
                    check(tag, "sweep unrep", int'(out_unrep), (v == -128 && d < 2) ? 1 : 0);
                    check(tag, "sweep negzero", int'(out_negzero),
                          ((s == 0 && p == 128) || (s == 1 && p == 255)) ? 1 : 0);
                end
            end
        end
    endtask

    // R5: the worked value -123 in each format
    task automatic test_worked();
        conv_check("R5", 2, 0, 8'h85, 8'hFB, 0, 0);
        conv_check("R5", 2, 1, 8'h85, 8'h84, 0, 0);
        conv_check("R5", 2, 3, 8'h85, 8'h05, 0, 0);
        conv_check("R5", 0, 2, 8'hFB, 8'h85, 0, 0);
        conv_check("R5", 1, 3, 8'h84, 8'h05, 0, 0);
    endtask

    // R6: most negative value into the formats that cannot hold it
    task automatic test_saturate();
        conv_check("R6", 2, 0, 8'h80, 8'hFF, 1, 0);
        conv_check("R6", 3, 1, 8'h00, 8'h80, 1, 0);
    endtask

    // R7: most negative value into formats that can hold it
    task automatic test_exact_min();
        conv_check("R7", 2, 3, 8'h80, 8'h00, 0, 0);
        conv_check("R7", 3, 2, 8'h00, 8'h80, 0, 0);
    endtask

    // R8: negative zeros map to the destination's zero
    task automatic test_negzero();
        conv_check("R8", 0, 3, 8'h80, 8'h80, 0, 1);
        conv_check("R8", 1, 0, 8'hFF, 8'h00, 0, 1);
        conv_check("R8", 0, 1, 8'h80, 8'h00, 0, 1);
    endtask

    // R9: valid is delayed by exactly one clock
    task automatic test_latency();
        @(negedge clk);
        in_valid = 1'b1; src_fmt = 2'b10; dst_fmt = 2'b00; in_data = 8'hF6;
        check("R9", "valid before edge", int'(out_valid), 0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", "valid after one clock", int'(out_valid), 1);
        check("R9", "data after one clock", int'(out_data), 8'h8A);
        @(negedge clk);
        check("R9", "valid drops", int'(out_valid), 0);
    endtask

    // R11: with valid low, data holds and flags stay low
    task automatic test_hold();
        drive(2, 0, 8'h80);
        check("R11", "loaded data", int'(out_data), 8'hFF);
        @(negedge clk);
        in_valid = 1'b0; src_fmt = 2'b00; dst_fmt = 2'b01; in_data = 8'h80;
        @(negedge clk);
        check("R11", "data held", int'(out_data), 8'hFF);
        check("R11", "unrep low", int'(out_unrep), 0);
        check("R11", "negzero low", int'(out_negzero), 0);
        check("R11", "valid low", int'(out_valid), 0);
    endtask

    initial begin
        test_reset();
        test_worked();
        test_saturate();
        test_exact_min();
        test_negzero();
        test_latency();
        test_hold();
        test_sweep();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule